// File: doc/BRIEF.md
# Coprocessor Periodic Wakeup Sequencer

This block sets the duty cycle of a small low-power coprocessor. A run command arms it. It then counts ticks of a slow time base up to a programmed threshold and raises a power request. After a fixed settling delay it lets the coprocessor out of reset, pointing it at the entry address that came with the run command. The coprocessor ends a run by pulsing done or by pulsing trap. The sequencer then removes power, samples the threshold again and starts a new interval from zero. Each interval is therefore timed from the end of one run to the start of the next.

A sleep-enable bit stops further wakeups. Both the host and the coprocessor can clear it. If the bit is cleared during a run, that run still finishes, and the sequencer then goes back to idle instead of re-arming. The slow time base reaches the block as a one-cycle tick strobe in the block's own clock domain. The status port shows the state, the enable bit and whether the most recent halt was a trap.

Top module: `wakeup_seq`

## Requirements
- R1: While reset is high, and right after it, `state_o` is 0, `pwr_req_o`, `rst_rel_o`, `trap_flag_o` and `sleep_en_o` are 0.
- R2: `state_o` encodes idle=0, counting=1, powering=2, running=3. In idle the block ignores ticks. A `start_i` pulse in idle sets `sleep_en_o`, latches `entry_i` and `thresh_i`, and makes `state_o` 1 one cycle later.
- R3: In counting, each cycle with `tick_i` high adds one tick. The edge that samples the tick bringing the count up to the latched threshold moves the state to powering. A threshold of 0 counts as 1. In powering, `pwr_req_o` is 1 and `rst_rel_o` is 0.
- R4: In powering, the edge that samples the SETTLE_TICKS-th tick moves the state to running. In running, `rst_rel_o` and `pwr_req_o` are 1 and `entry_o` holds the latched entry address.
- R5: A `done_i` pulse in running ends the run. `pwr_req_o` and `rst_rel_o` drop one cycle later, and the state returns to counting with the count at zero and the threshold sampled again from `thresh_i`.
- R6: A `trap_i` pulse in running ends the run in the same way and sets `trap_flag_o` to 1. A halt by `done_i` alone sets it to 0. If both arrive together, the flag is set to 1. The flag changes only at a halt.
- R7: `done_i` and `trap_i` have no effect in idle, counting or powering.
- R8: A `host_en_clr_i` pulse in counting clears `sleep_en_o` and returns the state to idle on the same edge. No wakeup follows.
- R9: A `core_en_clr_i` pulse behaves the same as `host_en_clr_i`.
- R10: If the enable bit is cleared in powering or running, the run still takes place and completes. At its halt the state goes to idle, not counting.
- R11: `start_i` outside idle has no effect. In particular, `entry_o` does not change.
- R12: A change of `thresh_i` during counting does not affect the current interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle strobe per slow-clock tick |
| start_i | input | 1 | Run command pulse |
| thresh_i | input | TW | Interval length in ticks |
| entry_i | input | AW | Coprocessor start address |
| host_en_clr_i | input | 1 | Host clears the sleep enable |
| core_en_clr_i | input | 1 | Coprocessor clears the sleep enable |
| done_i | input | 1 | Coprocessor completion pulse |
| trap_i | input | 1 | Coprocessor trap pulse |
| pwr_req_o | output | 1 | Power-up request |
| rst_rel_o | output | 1 | Coprocessor reset release |
| entry_o | output | AW | Latched start address |
| state_o | output | 2 | Sequencer state code |
| trap_flag_o | output | 1 | Last halt was a trap |
| sleep_en_o | output | 1 | Sleep-timer enable bit |

## Verification
The hardest case to reach is a halt that coincides with other events. These include a trap together with done, an enable clear that lands during powering or running, and a re-arm that must pick up a threshold changed while the previous interval was still counting. The stimulus gets there with directed sequences. Tick pulses are issued one at a time so the exact tick of each transition is known. Threshold, entry and clear inputs are changed at chosen points inside an interval. A behavioural model in the bench follows every cycle and is compared against all outputs.

// File: rtl/wk_pkg.sv
package wk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_POWER = 2'd2,
        ST_RUN   = 2'd3
    } wk_state_e;

    typedef struct packed {
        logic done;
        logic trap;
    } wk_halt_t;

    function automatic wk_state_e halt_target(input logic en_after);
        return en_after ? ST_COUNT : ST_IDLE;
    endfunction

    function automatic logic is_powered(input wk_state_e s);
        return (s == ST_POWER) || (s == ST_RUN);
    endfunction

endpackage

// File: rtl/wk_tick_counter.sv
module wk_tick_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_i,
    input  logic         tick_i,
    input  logic [W-1:0] limit_i,
    output logic         hit_o
);
    logic [W-1:0] cnt_q;
    logic [W:0]   nxt;

    assign nxt   = (W+1)'(cnt_q) + (W+1)'(1);
    assign hit_o = ~clear_i & tick_i & (nxt >= {1'b0, limit_i});

    always_ff @(posedge clk) begin
        if (rst || clear_i)
            cnt_q <= '0;
        else if (tick_i)
            cnt_q <= nxt[W-1:0];
    end

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
        !clear_i |-> (cnt_q < limit_i)); // R3
endmodule

// File: rtl/wk_seq_fsm.sv
module wk_seq_fsm
    import wk_pkg::*;
#(
    parameter int TW = 16,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [TW-1:0] thresh_i,
    input  logic [AW-1:0] entry_i,
    input  logic          host_clr_i,
    input  logic          core_clr_i,
    input  logic          done_i,
    input  logic          trap_i,
    input  logic          wake_hit_i,
    input  logic          settle_hit_i,
    output wk_state_e     state_o,
    output logic [TW-1:0] thr_o,
    output logic [AW-1:0] entry_o,
    output logic          trap_flag_o,
    output logic          en_o
);
    wk_state_e     state_q, state_d;
    logic [TW-1:0] thr_q;
    logic [AW-1:0] entry_q;
    logic          trap_q, en_q, en_d;
    wk_halt_t      halt;
    logic          halting;
    logic [TW-1:0] thr_sample;

    assign halt       = '{done: done_i, trap: trap_i};
    assign halting    = (state_q == ST_RUN) && (halt.done || halt.trap);
    assign thr_sample = (thresh_i == '0) ? TW'(1) : thresh_i;

    always_comb begin
        en_d    = en_q & ~(host_clr_i | core_clr_i);
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) begin
                state_d = ST_COUNT;
                en_d    = 1'b1;
            end
            ST_COUNT: begin
                if (!en_d)           state_d = ST_IDLE;
                else if (wake_hit_i) state_d = ST_POWER;
            end
            ST_POWER: if (settle_hit_i) state_d = ST_RUN;
            ST_RUN:   if (halting)      state_d = halt_target(en_d);
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            thr_q   <= TW'(1);
            entry_q <= '0;
            trap_q  <= 1'b0;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            en_q    <= en_d;
            if (state_q == ST_IDLE && start_i) begin
                entry_q <= entry_i;
                thr_q   <= thr_sample;
            end
            if (halting) begin
                trap_q <= halt.trap;
                thr_q  <= thr_sample;
            end
        end
    end

    assign state_o     = state_q;
    assign thr_o       = thr_q;
    assign entry_o     = entry_q;
    assign trap_flag_o = trap_q;
    assign en_o        = en_q;

    AST_WAKE_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == ST_COUNT && state_q == ST_POWER) |-> $past(wake_hit_i)); // R3
    AST_RUN_FROM_POWER: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && $past(state_q) != ST_RUN) |-> ($past(state_q) == ST_POWER && $past(settle_hit_i))); // R4
    AST_HALT_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == ST_RUN && state_q != ST_RUN) |-> $past(done_i || trap_i)); // R5
    AST_TRAP_ONLY_AT_HALT: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) != ST_RUN) |-> $stable(trap_q)); // R6
    AST_ENTRY_HELD: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) != ST_IDLE) |-> $stable(entry_q)); // R11
endmodule

// File: rtl/wakeup_seq.sv
module wakeup_seq
    import wk_pkg::*;
#(
    parameter int TW           = 16,
    parameter int AW           = 12,
    parameter int SETTLE_TICKS = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic          start_i,
    input  logic [TW-1:0] thresh_i,
    input  logic [AW-1:0] entry_i,
    input  logic          host_en_clr_i,
    input  logic          core_en_clr_i,
    input  logic          done_i,
    input  logic          trap_i,
    output logic          pwr_req_o,
    output logic          rst_rel_o,
    output logic [AW-1:0] entry_o,
    output logic [1:0]    state_o,
    output logic          trap_flag_o,
    output logic          sleep_en_o
);
    localparam int SW = $clog2(SETTLE_TICKS + 1);

    wk_state_e     state;
    logic [TW-1:0] thr;
    logic          wake_hit, settle_hit;

    wk_seq_fsm #(.TW(TW), .AW(AW)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .thresh_i     (thresh_i),
        .entry_i      (entry_i),
        .host_clr_i   (host_en_clr_i),
        .core_clr_i   (core_en_clr_i),
        .done_i       (done_i),
        .trap_i       (trap_i),
        .wake_hit_i   (wake_hit),
        .settle_hit_i (settle_hit),
        .state_o      (state),
        .thr_o        (thr),
        .entry_o      (entry_o),
        .trap_flag_o  (trap_flag_o),
        .en_o         (sleep_en_o)
    );

    wk_tick_counter #(.W(TW)) u_interval (
        .clk     (clk),
        .rst     (rst),
        .clear_i (state != ST_COUNT),
        .tick_i  (tick_i),
        .limit_i (thr),
        .hit_o   (wake_hit)
    );

    wk_tick_counter #(.W(SW)) u_settle (
        .clk     (clk),
        .rst     (rst),
        .clear_i (state != ST_POWER),
        .tick_i  (tick_i),
        .limit_i (SW'(SETTLE_TICKS)),
        .hit_o   (settle_hit)
    );

    assign state_o   = state;
    assign pwr_req_o = is_powered(state);
    assign rst_rel_o = (state == ST_RUN);

    AST_NO_RELEASE_UNPOWERED: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_rel_o) |-> $past(pwr_req_o)); // R4
endmodule

// File: tb/wakeup_seq_bench.sv
module wakeup_seq_bench;
    localparam int TW = 8, AW = 12, ST = 3;

    logic clk = 0, rst = 1, tick_i = 0, start_i = 0;
    logic [TW-1:0] thresh_i = 0;
    logic [AW-1:0] entry_i = 0;
    logic host_en_clr_i = 0, core_en_clr_i = 0, done_i = 0, trap_i = 0;
    logic pwr_req_o, rst_rel_o, trap_flag_o, sleep_en_o;
    logic [AW-1:0] entry_o;
    logic [1:0] state_o;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    wakeup_seq #(.TW(TW), .AW(AW), .SETTLE_TICKS(ST)) u_wakeup_seq (.*);

    // behavioural reference model
    int m_state = 0, m_cnt = 0, m_set = 0, m_thr = 1, m_entry = 0;
    bit m_en = 0, m_trap = 0;

    always @(posedge clk) begin
        bit en_n;
        if (rst) begin
            m_state = 0; m_cnt = 0; m_set = 0; m_thr = 1; m_entry = 0; m_en = 0; m_trap = 0;
        end else begin
            en_n = m_en && !(host_en_clr_i || core_en_clr_i);
            case (m_state)
                0: if (start_i) begin
                        m_state = 1; m_cnt = 0; m_entry = entry_i; en_n = 1;
                        m_thr = (thresh_i == 0) ? 1 : thresh_i;
                    end
                1: if (!en_n) m_state = 0;
                   else if (tick_i) begin
                        m_cnt++;
                        if (m_cnt >= m_thr) begin m_state = 2; m_set = 0; end
                   end
                2: if (tick_i) begin
                        m_set++;
                        if (m_set >= ST) m_state = 3;
                   end
                default: if (done_i || trap_i) begin
                        m_trap = trap_i;
                        m_thr = (thresh_i == 0) ? 1 : thresh_i;
                        m_cnt = 0;
                        m_state = en_n ? 1 : 0;
                   end
            endcase
            m_en = en_n;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #2;
        chk("R3 R4 lockstep state", state_o, m_state);
        chk("R3 R4 lockstep power", {pwr_req_o, rst_rel_o},
            {m_state >= 2 ? 1'b1 : 1'b0, m_state == 3 ? 1'b1 : 1'b0});
        chk("R6 R11 lockstep flags", {sleep_en_o, trap_flag_o}, {m_en, m_trap});
        chk("R11 lockstep entry", entry_o, m_entry);
    endtask

    task automatic ticks(int k);
        for (int i = 0; i < k; i++) begin
            tick_i = 1; cyc(); tick_i = 0; cyc();
        end
    endtask

    task automatic pulse(ref logic sig);
        sig = 1; cyc(); sig = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R1 reset state", state_o, 0);
        chk("R1 reset outputs", {pwr_req_o, rst_rel_o, trap_flag_o, sleep_en_o}, 0);
        rst = 0; cyc();
        chk("R1 after reset", state_o, 0);
        ticks(3); pulse(trap_i); pulse(done_i); cyc();
        chk("R2 idle ignores ticks", state_o, 0);
        chk("R7 trap in idle", trap_flag_o, 0);

        thresh_i = 3; entry_i = 12'h123; pulse(start_i);
        chk("R2 start to counting", state_o, 1);
        chk("R2 enable set", sleep_en_o, 1);
        thresh_i = 5;
        ticks(2);
        pulse(done_i); pulse(trap_i);
        chk("R7 done in counting", state_o, 1);
        chk("R12 old threshold kept", state_o, 1);
        ticks(1);
        chk("R3 powering", state_o, 2);
        chk("R3 power but held", {pwr_req_o, rst_rel_o}, 2'b10);
        pulse(trap_i);
        ticks(2);
        chk("R7 trap in powering", trap_flag_o, 0);
        ticks(1);
        chk("R4 running", state_o, 3);
        chk("R4 release", {pwr_req_o, rst_rel_o}, 2'b11);
        entry_i = 12'h055; pulse(start_i);
        chk("R11 entry kept", entry_o, 12'h123);
        pulse(trap_i);
        chk("R6 trap halt", trap_flag_o, 1);
        chk("R5 back to counting", {state_o, pwr_req_o}, {2'd1, 1'b0});
        ticks(4);
        chk("R5 new threshold five", state_o, 1);
        ticks(1);
        chk("R5 wake after five", state_o, 2);
        ticks(3);
        thresh_i = 0;
        pulse(done_i);
        chk("R6 done halt clears", trap_flag_o, 0);
        ticks(1);
        chk("R3 zero threshold", state_o, 2);
        ticks(3);
        host_en_clr_i = 1; cyc(); host_en_clr_i = 0; cyc();
        chk("R10 run continues", state_o, 3);
        pulse(done_i);
        chk("R10 idle after halt", state_o, 0);

        thresh_i = 4; pulse(start_i); ticks(1);
        pulse(core_en_clr_i);
        chk("R9 core clear", {state_o, sleep_en_o}, 0);
        ticks(5);
        chk("R9 no wake", pwr_req_o, 0);

        pulse(start_i); ticks(1);
        pulse(host_en_clr_i);
        chk("R8 host clear", {state_o, sleep_en_o}, 0);
        ticks(5);
        chk("R8 no wake", pwr_req_o, 0);

        thresh_i = 1; pulse(start_i); ticks(1);
        pulse(core_en_clr_i);
        ticks(3);
        chk("R10 clear in powering still runs", state_o, 3);
        done_i = 1; trap_i = 1; cyc(); done_i = 0; trap_i = 0;
        chk("R6 both pulses", trap_flag_o, 1);
        chk("R10 idle after powering clear", state_o, 0);
        cyc();

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        finished = 1;
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog actual=0 expected=1");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule